// File: doc/BRIEF.md
# Picture Tube Protection Controller

This block decides, clock by clock, whether a display deflection stage may drive its RGB outputs and whether horizontal drive may run. It watches a vertical flyback input, which must fall once in every field. A field-start strobe marks each field boundary. If a whole field passes without a falling flyback edge, the block blanks the RGB drive. It restores the drive at the first boundary that closes a field in which an edge was seen.

Two comparator flags report the analog safety level: one for the lower threshold and one for the upper. Each flag passes through an agreement filter, which stands in for threshold hysteresis. The filtered levels decode to three states. In the normal state nothing is blanked. In the middle state only RGB is blanked. In the top state RGB is blanked and horizontal drive is stopped as well.

A configuration bit lets software also blank RGB for as long as the flyback input is high.

Top module: `tube_guard`

## Requirements
- R1: When `field_strobe` is high at a clock edge and no falling flyback edge occurred in the field it closes, `rgb_blank` is 1 from just after that edge. It stays 1 through later fields until R3 restores it.
- R2: A falling flyback edge is a cycle in which `flyback_in` is 0 after being 1 in the previous cycle. A falling edge in the same cycle as `field_strobe` counts for the field that this strobe closes.
- R3: At a `field_strobe` edge that closes a field containing a falling flyback edge, the missing-edge blanking ends just after that edge.
- R4: With `cfg_fb_blank` = 1, `rgb_blank` is 1 in every cycle in which `flyback_in` is 1, with no delay. With `cfg_fb_blank` = 0, `flyback_in` by itself does not affect `rgb_blank`.
- R5: When both filtered safety levels are 0, the safety decode blanks nothing and `hdrive_en` is 1.
- R6: When the filtered lower level is 1 and the filtered upper level is 0, `rgb_blank` is 1 and `hdrive_en` stays 1.
- R7: When the filtered upper level is 1, `rgb_blank` is 1 and `hdrive_en` is 0, whatever the lower level is.
- R8: The filtered value of each comparator flag takes a new value only after the raw flag has differed from it at FILT_LEN consecutive clock edges (default 4). The new value takes effect just after the last of those edges. A shorter run of difference has no effect.
- R9: During and just after reset, `rgb_blank` is 0 (with `cfg_fb_blank` = 0), `hdrive_en` is 1, and both filtered levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_strobe | input | 1 | One-cycle pulse at each field boundary |
| flyback_in | input | 1 | Vertical flyback input, high during flyback |
| safe_lo | input | 1 | Comparator flag: safety level above lower threshold |
| safe_hi | input | 1 | Comparator flag: safety level above upper threshold |
| cfg_fb_blank | input | 1 | Software option: blank RGB while flyback is high |
| rgb_blank | output | 1 | 1 blanks the RGB drive |
| hdrive_en | output | 1 | 1 lets horizontal drive run |

## Verification
A stuck or wrongly cleared edge-seen flag shows at `rgb_blank` in the cycle right after the next field strobe. That field is either blanked when it should not be or left unblanked when it should be. An error in a filter's run counter moves the level change on `rgb_blank` or `hdrive_en` by at least one cycle. It can also let a chatter burst shorter than FILT_LEN through. A bench model compared on every clock catches either fault within one cycle of the first wrong edge.

// File: rtl/tg_pkg.sv
package tg_pkg;
    typedef enum logic [1:0] {
        LVL_OK    = 2'd0,
        LVL_BLANK = 2'd1,
        LVL_CUT   = 2'd2
    } lvl_e;
endpackage

// File: rtl/tg_agree_filter.sv
module tg_agree_filter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] run;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw != st_q.lvl) begin
            if (st_q.run == LAST) begin
                st_d.lvl = raw;
                st_d.run = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;

    // R8: a new filtered value must agree with the raw input of the last two edges
    generate
        if (LEN >= 2) begin : g_chk
            a_r8_agree: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(level) |-> ($past(raw) == level && $past(raw, 2) == level));
        end
    endgenerate
endmodule

// File: rtl/tg_field_watch.sv
module tg_field_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic fb,
    output logic missing
);
    typedef struct packed {
        logic fb_prev;
        logic seen;
        logic miss;
    } fw_t;

    fw_t st_d, st_q;
    logic fall;

    always_comb begin
        fall = st_q.fb_prev & ~fb;
        st_d = st_q;
        st_d.fb_prev = fb;
        if (strobe) begin
            st_d.miss = ~(st_q.seen | fall);
            st_d.seen = 1'b0;
        end else if (fall) begin
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign missing = st_q.miss;

    // R1: the missing-edge flag moves only at field boundaries
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(missing));
    // R2: a falling edge on the boundary cycle counts for the closing field
    a_r2_edge_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(fb) && !fb) |=> !missing);
endmodule

// File: rtl/tg_level_decode.sv
module tg_level_decode
    import tg_pkg::*;
(
    input  logic lo,
    input  logic hi,
    output lvl_e lvl
);
    always_comb begin
        if (hi)      lvl = LVL_CUT;
        else if (lo) lvl = LVL_BLANK;
        else         lvl = LVL_OK;
    end
endmodule

// File: rtl/tube_guard.sv
module tube_guard
    import tg_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic field_strobe,
    input  logic flyback_in,
    input  logic safe_lo,
    input  logic safe_hi,
    input  logic cfg_fb_blank,
    output logic rgb_blank,
    output logic hdrive_en
);
    logic lo_f, hi_f, miss;
    lvl_e lvl;

    tg_agree_filter #(.LEN(FILT_LEN)) u_flt_lo (
        .clk(clk), .rst_n(rst_n), .raw(safe_lo), .level(lo_f)
    );
    tg_agree_filter #(.LEN(FILT_LEN)) u_flt_hi (
        .clk(clk), .rst_n(rst_n), .raw(safe_hi), .level(hi_f)
    );
    tg_field_watch u_fw (
        .clk(clk), .rst_n(rst_n), .strobe(field_strobe), .fb(flyback_in), .missing(miss)
    );
    tg_level_decode u_dec (
        .lo(lo_f), .hi(hi_f), .lvl(lvl)
    );

    always_comb begin
        rgb_blank = miss | (lvl != LVL_OK) | (cfg_fb_blank & flyback_in);
        hdrive_en = (lvl != LVL_CUT);
    end

    // R7: horizontal drive never runs stopped while RGB is driven
    a_r7_cut_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        !hdrive_en |-> rgb_blank);
    // R4: flyback blanking option is immediate
    a_r4_fb_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fb_blank && flyback_in) |-> rgb_blank);
    // R6: lower threshold alone keeps horizontal drive running
    a_r6_lo_only: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_f && !hi_f) |-> (rgb_blank && hdrive_en));
endmodule

// File: tb/sim_tube_guard.sv
`timescale 1ns/1ps
module sim_tube_guard;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic field_strobe = 1'b0, flyback_in = 1'b0, safe_lo = 1'b0, safe_hi = 1'b0, cfg_fb_blank = 1'b0;
    logic rgb_blank, hdrive_en;

    int total = 0;
    int bad = 0;
    string tag = "R9";

    // model state
    bit m_fbprev = 0, m_seen = 0, m_miss = 0, m_lo = 0, m_hi = 0;
    int m_rlo = 0, m_rhi = 0;

    always #2 clk = ~clk;

    tube_guard #(.FILT_LEN(N)) u0 (
        .clk(clk), .rst_n(rst_n), .field_strobe(field_strobe), .flyback_in(flyback_in),
        .safe_lo(safe_lo), .safe_hi(safe_hi), .cfg_fb_blank(cfg_fb_blank),
        .rgb_blank(rgb_blank), .hdrive_en(hdrive_en)
    );

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", t, act, exp, $time);
        end
    endtask

    // behavioural reference updated on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_fbprev = 0; m_seen = 0; m_miss = 0; m_lo = 0; m_hi = 0; m_rlo = 0; m_rhi = 0;
        end else begin
            bit fall;
            fall = m_fbprev && !flyback_in;
            if (field_strobe) begin
                m_miss = !(m_seen || fall);
                m_seen = 0;
            end else if (fall) m_seen = 1;
            m_fbprev = flyback_in;
            if (safe_lo != m_lo) begin
                m_rlo++;
                if (m_rlo == N) begin m_lo = safe_lo; m_rlo = 0; end
            end else m_rlo = 0;
            if (safe_hi != m_hi) begin
                m_rhi++;
                if (m_rhi == N) begin m_hi = safe_hi; m_rhi = 0; end
            end else m_rhi = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit eb, eh;
            eb = m_miss || m_lo || m_hi || (cfg_fb_blank && flyback_in);
            eh = !m_hi;
            chk(rgb_blank == eb, {tag, " rgb_blank"}, rgb_blank, eb);
            chk(hdrive_en == eh, {tag, " hdrive_en"}, hdrive_en, eh);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic strobe();
        field_strobe = 1'b1; step(1); field_strobe = 1'b0;
    endtask

    task automatic pulse(input int len);
        flyback_in = 1'b1; step(len); flyback_in = 1'b0;
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        step(3);
        at_neg();
        chk(rgb_blank == 0, "R9 reset blank", rgb_blank, 0);
        chk(hdrive_en == 1, "R9 reset hdrive", hdrive_en, 1);
        rst_n = 1'b1;
        step(2);
        at_neg();
        chk(rgb_blank == 0 && hdrive_en == 1, "R9 after reset", rgb_blank, 0);

        // R3/R5: healthy fields
        tag = "R5";
        for (int f = 0; f < 3; f++) begin
            step(3); pulse(4); step(5); strobe();
        end
        at_neg();
        chk(rgb_blank == 0, "R5 normal fields", rgb_blank, 0);
        chk(hdrive_en == 1, "R5 hdrive normal", hdrive_en, 1);

        // R1: field without an edge
        tag = "R1";
        step(10); strobe();
        at_neg();
        chk(rgb_blank == 1, "R1 missing edge blanks", rgb_blank, 1);
        step(6); strobe();
        at_neg();
        chk(rgb_blank == 1, "R1 blank persists", rgb_blank, 1);

        // R3: restore
        tag = "R3";
        step(2); pulse(3); step(4);
        at_neg();
        chk(rgb_blank == 1, "R3 not before boundary", rgb_blank, 1);
        strobe();
        at_neg();
        chk(rgb_blank == 0, "R3 restored at boundary", rgb_blank, 0);

        // R2: falling edge on the strobe cycle
        tag = "R2";
        step(5); flyback_in = 1'b1; step(3);
        flyback_in = 1'b0; field_strobe = 1'b1; step(1); field_strobe = 1'b0;
        at_neg();
        chk(rgb_blank == 0, "R2 edge on strobe counts", rgb_blank, 0);
        step(4); strobe();
        at_neg();
        chk(rgb_blank == 1, "R2 edge not reused next field", rgb_blank, 1);
        step(2); pulse(2); step(2); strobe();

        // R4: flyback blanking option
        tag = "R4";
        cfg_fb_blank = 1'b1; step(2); flyback_in = 1'b1;
        at_neg();
        chk(rgb_blank == 1, "R4 fb blank on", rgb_blank, 1);
        step(2); flyback_in = 1'b0;
        at_neg();
        chk(rgb_blank == 0, "R4 fb blank released", rgb_blank, 0);
        cfg_fb_blank = 1'b0; step(1); flyback_in = 1'b1;
        at_neg();
        chk(rgb_blank == 0, "R4 option off no effect", rgb_blank, 0);
        step(2); flyback_in = 1'b0; step(3); strobe();

        // R8: chatter on lower flag
        tag = "R8";
        safe_lo = 1'b1; step(N - 1); safe_lo = 1'b0;
        at_neg();
        chk(rgb_blank == 0, "R8 short lo chatter ignored", rgb_blank, 0);
        step(2);

        // R6: lower threshold held
        tag = "R6";
        safe_lo = 1'b1; step(N - 1);
        at_neg();
        chk(rgb_blank == 0, "R8 lo not yet", rgb_blank, 0);
        step(1);
        at_neg();
        chk(rgb_blank == 1, "R6 lo blanks", rgb_blank, 1);
        chk(hdrive_en == 1, "R6 hdrive kept", hdrive_en, 1);

        // R7: upper threshold
        tag = "R7";
        safe_hi = 1'b1; step(N - 2); safe_hi = 1'b0; step(1);
        at_neg();
        chk(hdrive_en == 1, "R8 short hi chatter ignored", hdrive_en, 1);
        safe_hi = 1'b1; step(N);
        at_neg();
        chk(hdrive_en == 0, "R7 hi cuts hdrive", hdrive_en, 0);
        chk(rgb_blank == 1, "R7 hi blanks", rgb_blank, 1);
        safe_lo = 1'b0; step(N + 1);
        at_neg();
        chk(hdrive_en == 0, "R7 hi alone cuts", hdrive_en, 0);

        // release, back to normal
        tag = "R5";
        safe_hi = 1'b0; step(N);
        at_neg();
        chk(hdrive_en == 1 && rgb_blank == 0, "R5 back to normal", hdrive_en, 1);
        step(3);
        summary();
        $finish;
    end
endmodule